// File: doc/BRIEF.md
# Periodic Dither Generator with Synchronous Decimator

This block produces a deterministic dither ramp for an ADC front end and removes it again by averaging. A 4-bit code on four output pins drives a binary-weighted resistor network that is summed into the converter's reference. Each time the converter delivers a sample, the block takes in the reading and then steps the code by one. The code climbs from 0 to 15 and wraps, so one full dither period covers sixteen raw samples.

The raw readings are summed over a window that begins with the sample taken at code 0 and ends with the sample taken at code 15. At the end of the window the block emits the sum divided by sixteen as one decimated sample, together with a one-clock valid pulse. Because each window spans exactly one dither period, the added dither is the same in every window and its ripple cancels out. With a 250 kSps sample strobe, decimated samples appear at 15.625 kSps.

Top module: `dither_decim`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge) the dither pins read 0, `decimValid` is low and `decimData` is 0. No valid pulse appears until a complete sixteen-sample window has been captured.
- R2: Every clock edge with `sampleStrobe` high advances `ditherPins` by one. After 15 the value wraps to 0.
- R3: On edges with `sampleStrobe` low, `ditherPins` holds its value and `adcData` has no effect on any later output.
- R4: A sample captured at a strobe edge belongs to the code that `ditherPins` shows during that clock. The code changes only after that edge.
- R5: A window opens with the sample taken at code 0. The sum restarts there, so no earlier window contributes to it.
- R6: `decimData` is the two's-complement sum of the sixteen signed 14-bit samples of the window, divided by 16 and rounded toward minus infinity. The sum is held in an 18-bit register and cannot overflow, even at full-scale inputs of +8191 or -8192.
- R7: `decimValid` is high for exactly one clock, the clock after the edge that captures the code-15 sample. `decimData` takes its new value in that same clock and holds it until the next pulse.
- R8: A reset in the middle of a window discards the partial sum. The next result comes only from sixteen samples taken after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleStrobe | input | 1 | One-clock pulse when an ADC reading is ready |
| adcData | input | 14 | Signed ADC reading, valid when the strobe is high |
| ditherPins | output | 4 | Dither code to the resistor DAC |
| decimData | output | 14 | Signed averaged sample |
| decimValid | output | 1 | One-clock pulse marking a new decimated sample |

## Verification
The assertions assume that `sampleStrobe` is a clean synchronous pulse and that reset is held for at least two clocks. They also assume that `adcData` matters only in clocks where the strobe is high. The stimulus raises the strobe for single clocks, including back-to-back clocks, and fills the idle gaps with junk data. This shows that only strobed readings enter the sum. The ramp checks rely on strobes arriving one at a time. The valid-pulse check relies on at least one idle clock or one further strobe between windows, and the bench keeps to both.

// File: rtl/dither_decim_pkg.sv
package dither_decim_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // first sample of a window: restart the sum
    logic accum;  // any later sample: add to the sum
    logic emit;   // last sample: publish the average
  } dpStrobe_t;
endpackage

// File: rtl/dither_decim_ctrl.sv
module dither_decim_ctrl
  import dither_decim_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleStrobe,
  output logic [CODE_W-1:0] code,
  output dpStrobe_t         strobes
);
  localparam logic [CODE_W-1:0] LAST_CODE = {CODE_W{1'b1}};

  logic [CODE_W-1:0] codeReg;

  always_ff @(posedge clk) begin
    if (rst)               codeReg <= '0;
    else if (sampleStrobe) codeReg <= codeReg + 1'b1;
  end

  always_comb begin
    strobes.load  = sampleStrobe && (codeReg == '0);
    strobes.accum = sampleStrobe && (codeReg != '0);
    strobes.emit  = sampleStrobe && (codeReg == LAST_CODE);
  end

  assign code = codeReg;
endmodule

// File: rtl/dither_decim_datapath.sv
module dither_decim_datapath
  import dither_decim_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int CODE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  dpStrobe_t                strobes,
  input  logic signed [DATA_W-1:0] sample,
  output logic signed [DATA_W-1:0] avgOut,
  output logic                     avgValid
);
  localparam int ACC_W = DATA_W + CODE_W;

  logic signed [ACC_W-1:0] accReg;
  logic signed [ACC_W-1:0] sampleExt;
  logic signed [ACC_W-1:0] accNext;

  always_comb begin
    sampleExt = {{CODE_W{sample[DATA_W-1]}}, sample};
    accNext   = strobes.load ? sampleExt : accReg + sampleExt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accReg   <= '0;
      avgOut   <= '0;
      avgValid <= 1'b0;
    end else begin
      avgValid <= strobes.emit;
      if (strobes.load || strobes.accum) accReg <= accNext;
      // Taking the upper bits divides by the window length and rounds toward minus infinity
      if (strobes.emit) avgOut <= accNext[ACC_W-1:CODE_W];
    end
  end
endmodule

// File: rtl/dither_decim.sv
module dither_decim
  import dither_decim_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int CODE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sampleStrobe,
  input  logic signed [DATA_W-1:0] adcData,
  output logic        [CODE_W-1:0] ditherPins,
  output logic signed [DATA_W-1:0] decimData,
  output logic                     decimValid
);
  dpStrobe_t strobes;

  dither_decim_ctrl #(.CODE_W(CODE_W)) ctrl (
    .clk(clk), .rst(rst), .sampleStrobe(sampleStrobe),
    .code(ditherPins), .strobes(strobes)
  );

  dither_decim_datapath #(.DATA_W(DATA_W), .CODE_W(CODE_W)) dp (
    .clk(clk), .rst(rst), .strobes(strobes), .sample(adcData),
    .avgOut(decimData), .avgValid(decimValid)
  );
endmodule

// File: rtl/dither_decim_chk.sv
module dither_decim_chk #(
  parameter int DATA_W = 14,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sampleStrobe,
  input logic [CODE_W-1:0] ditherPins,
  input logic [DATA_W-1:0] decimData,
  input logic              decimValid
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (ditherPins == '0 && !decimValid));

  // R2
  pins_advance_chk: assert property (@(posedge clk) disable iff (rst)
    sampleStrobe |=> ditherPins == CODE_W'($past(ditherPins) + 1'b1));

  // R3
  pins_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sampleStrobe |=> $stable(ditherPins));

  // R7
  valid_source_chk: assert property (@(posedge clk) disable iff (rst)
    decimValid |-> ($past(sampleStrobe) && $past(ditherPins) == {CODE_W{1'b1}}));

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    decimValid |=> !decimValid);

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(decimData) |-> decimValid);
endmodule

bind dither_decim dither_decim_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) chk (
  .clk(clk), .rst(rst), .sampleStrobe(sampleStrobe), .ditherPins(ditherPins),
  .decimData(decimData), .decimValid(decimValid)
);

// File: tb/dither_decim_test.sv
module dither_decim_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleStrobe = 1'b0;
  logic signed [13:0] adcData = '0;
  logic [3:0] ditherPins;
  logic signed [13:0] decimData;
  logic decimValid;

  int testCount = 0;
  int failCount = 0;

  always #4 clk = ~clk;

  dither_decim uut (
    .clk(clk), .rst(rst), .sampleStrobe(sampleStrobe), .adcData(adcData),
    .ditherPins(ditherPins), .decimData(decimData), .decimValid(decimValid)
  );

  // Each entry: first sample, step between samples, expected average
  localparam int NVEC = 8;
  localparam int VEC [NVEC][3] = '{
    '{0, 0, 0}, '{100, 0, 100}, '{-100, 0, -100}, '{0, 1, 7},
    '{0, -1, -8}, '{8191, 0, 8191}, '{-8192, 0, -8192}, '{1000, -3, 977}
  };

  task automatic check(input string req, input int actual, input int expected);
    testCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // One strobed sample; checks at the falling edge after the capturing edge
  task automatic sendSample(input int value, input int idx, input int gap, input int expAvg);
    sampleStrobe = 1'b1;
    adcData = 14'(value);
    @(negedge clk);
    sampleStrobe = 1'b0;
    adcData = 14'sh1555;  // junk while not strobed (R3)
    check("R2 pins advance", int'(ditherPins), (idx + 1) % 16);
    check("R7 valid timing", int'(decimValid), (idx == 15) ? 1 : 0);
    if (idx == 15) check("R6 average", int'(decimData), expAvg);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check("R3 pins hold", int'(ditherPins), (idx + 1) % 16);
      check("R7 single pulse", int'(decimValid), 0);
    end
  endtask

  task automatic sendWindow(input int base, input int step, input int expAvg, input int gap);
    for (int i = 0; i < 16; i++) begin
      check("R4 code before capture", int'(ditherPins), i);
      sendSample(base + step * i, i, gap, expAvg);
    end
  endtask

  initial begin
    #(8 * 200000);
    failCount++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pins after reset", int'(ditherPins), 0);
    check("R1 valid after reset", int'(decimValid), 0);
    check("R1 data after reset", int'(decimData), 0);
    rst = 1'b0;
    @(negedge clk);

    // R5 R6 R7 table of windows, the gap between strobes varies from 0 to 2
    for (int v = 0; v < NVEC; v++) begin
      sendWindow(VEC[v][0], VEC[v][1], VEC[v][2], v % 3);
      check("R5 data held between windows", int'(decimData), VEC[v][2]);
    end

    // R8 reset in the middle of a window discards the partial sum
    for (int i = 0; i < 5; i++) sendSample(5000, i, 1, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 pins cleared", int'(ditherPins), 0);
    check("R8 valid low", int'(decimValid), 0);
    rst = 1'b0;
    @(negedge clk);
    sendWindow(-20, 0, -20, 1);

    // R3 long idle stretch with junk data: no pin change, output unchanged
    for (int k = 0; k < 10; k++) begin
      adcData = 14'(k * 777);
      @(negedge clk);
    end
    check("R3 pins idle", int'(ditherPins), 0);
    check("R3 data idle", int'(decimData), -20);
    sendWindow(3, 2, 18, 0);  // 3 + floor(15) = 18

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule